// File: doc/BRIEF.md
# Earpiece Volume and Mute Controller

This block holds the receive gain setting and the mute states of a telephone handset. It works from single-cycle key strobes that a keypad scanner has already decoded. Two volume schemes share one gain register:

- A boost key toggles a fixed lift of +4 dB.
- Separate up and down keys move the gain in 2 dB steps. The range above default is larger than the range below it.

A privacy key mutes the microphone while the set is in speech mode. Any other key entry cancels that mute, and a reminder-tone enable stays high for as long as the mute holds. While dialling is active, the receive path is muted. A rising edge on the hook input (the handset going off-hook) returns every setting to default.

The gain output is a signed step count in 2 dB units, where 0 is the default gain. An analog gain stage and a tone generator downstream consume these outputs. Their design is not part of this block.

Top module: `volmute_ctrl`

## Requirements
- R1: After reset, gain_o is 0 and mic_mute_o and remind_o are 0.
- R2: A boost press when the boost is not engaged sets gain_o to +2 and engages the boost. A boost press while the boost is engaged sets gain_o to 0 and releases the boost.
- R3: An up press raises gain_o by one step and stops at +3. Further up presses leave gain_o at +3.
- R4: A down press lowers gain_o by one step and stops at -2. Further down presses leave gain_o at -2.
- R5: An up or down press releases the boost and steps from the current gain. If several volume keys arrive in one cycle, the boost key takes priority over up, and up takes priority over down.
- R6: When hook_i rises, gain_o, the boost state and the privacy mute are all cleared on the next clock edge. This takes priority over any key in the same cycle.
- R7: A mute press with speech_i high toggles mic_mute_o. A mute press with speech_i low has no effect.
- R8: A press of any key other than mute (boost, up, down or other) clears an active privacy mute. This takes priority over a mute press in the same cycle.
- R9: remind_o equals the privacy mute state, and rx_mute_o follows dialing_i in the same cycle.
- R10: Every output changes one clock edge after the key strobe that causes it, except rx_mute_o, which is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hook_i | input | 1 | Hook state; 1 means off-hook |
| speech_i | input | 1 | Speech mode active |
| dialing_i | input | 1 | Dialling in progress |
| vol_key_i | input | 1 | Boost key strobe |
| up_key_i | input | 1 | Volume-up key strobe |
| dn_key_i | input | 1 | Volume-down key strobe |
| mute_key_i | input | 1 | Privacy mute key strobe |
| other_key_i | input | 1 | Strobe for any other key entry |
| gain_o | output | 3 | Signed receive gain in 2 dB steps |
| mic_mute_o | output | 1 | Microphone muted (privacy) |
| rx_mute_o | output | 1 | Receive path muted |
| remind_o | output | 1 | Reminder tone enable |

## Verification
The bench builds the block with the default limits: three up steps, two down steps and a boost of two steps. Both saturation points are therefore only a few presses away, and random key traffic reaches them often. Random strobes that overlap in the same cycle exercise the priority between the volume keys and the clearing on a hook rise. Random toggling of speech mode exercises mute presses both inside and outside speech mode.

// File: rtl/volmute_pkg.sv
package volmute_pkg;
  localparam int GAIN_W = 3;
  typedef logic signed [GAIN_W-1:0] gain_t;
endpackage

// File: rtl/vm_hook_edge.sv
module vm_hook_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hook_i,
  output logic rise_o
);
  logic hook_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hook_q <= 1'b0;
    else         hook_q <= hook_i;
  end

  assign rise_o = hook_i & ~hook_q;
endmodule

// File: rtl/vm_gain.sv
module vm_gain
  import volmute_pkg::*;
#(
  parameter int MAX_UP = 3,
  parameter int MAX_DN = 2,
  parameter int BOOST  = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  vol_i,
  input  logic  up_i,
  input  logic  dn_i,
  output gain_t gain_o
);
  localparam gain_t G_MAX   = gain_t'(MAX_UP);
  localparam gain_t G_MIN   = gain_t'(-MAX_DN);
  localparam gain_t G_BOOST = gain_t'(BOOST);

  gain_t gain_q, gain_d;
  logic  boost_q, boost_d;

  always_comb begin
    gain_d  = gain_q;
    boost_d = boost_q;
    if (clr_i) begin
      gain_d  = '0;
      boost_d = 1'b0;
    end else if (vol_i) begin
      boost_d = ~boost_q;
      gain_d  = boost_q ? gain_t'(0) : G_BOOST;
    end else if (up_i) begin
      boost_d = 1'b0;
      if (gain_q < G_MAX) gain_d = gain_q + gain_t'(1);
    end else if (dn_i) begin
      boost_d = 1'b0;
      if (gain_q > G_MIN) gain_d = gain_q - gain_t'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q  <= '0;
      boost_q <= 1'b0;
    end else begin
      gain_q  <= gain_d;
      boost_q <= boost_d;
    end
  end

  assign gain_o = gain_q;

  // R3 R4
  gain_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_q <= G_MAX) && (gain_q >= G_MIN));
  // R3
  sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && !vol_i && !clr_i && gain_q == G_MAX) |=> (gain_q == G_MAX));
  // R4
  sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i && !up_i && !vol_i && !clr_i && gain_q == G_MIN) |=> (gain_q == G_MIN));
  // R6
  clr_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (gain_q == '0 && !boost_q));
endmodule

// File: rtl/vm_mute.sv
module vm_mute (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic speech_i,
  input  logic mute_i,
  input  logic cancel_i,
  output logic priv_o
);
  logic priv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 priv_q <= 1'b0;
    else if (clr_i || cancel_i)  priv_q <= 1'b0;
    else if (mute_i && speech_i) priv_q <= ~priv_q;
  end

  assign priv_o = priv_q;

  // R7
  mute_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!speech_i && !clr_i && !cancel_i) |=> $stable(priv_q));
  // R8
  cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !priv_q);
endmodule

// File: rtl/volmute_ctrl.sv
module volmute_ctrl
  import volmute_pkg::*;
#(
  parameter int MAX_UP = 3,
  parameter int MAX_DN = 2,
  parameter int BOOST  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hook_i,
  input  logic              speech_i,
  input  logic              dialing_i,
  input  logic              vol_key_i,
  input  logic              up_key_i,
  input  logic              dn_key_i,
  input  logic              mute_key_i,
  input  logic              other_key_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              mic_mute_o,
  output logic              rx_mute_o,
  output logic              remind_o
);
  logic  rise;
  logic  priv;
  logic  cancel;
  gain_t gain;

  vm_hook_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hook_i (hook_i),
    .rise_o (rise)
  );

  vm_gain #(.MAX_UP(MAX_UP), .MAX_DN(MAX_DN), .BOOST(BOOST)) i_gain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rise),
    .vol_i  (vol_key_i),
    .up_i   (up_key_i),
    .dn_i   (dn_key_i),
    .gain_o (gain)
  );

  // every non-mute key entry cancels privacy mute
  assign cancel = vol_key_i | up_key_i | dn_key_i | other_key_i;

  vm_mute i_mute (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rise),
    .speech_i (speech_i),
    .mute_i   (mute_key_i),
    .cancel_i (cancel),
    .priv_o   (priv)
  );

  assign gain_o     = gain;
  assign mic_mute_o = priv;
  assign remind_o   = priv;
  assign rx_mute_o  = dialing_i;

  // R6
  hook_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hook_i && !$past(hook_i)) |=> (!mic_mute_o && gain_o == '0));
endmodule

// File: tb/test_volmute_ctrl.sv
module test_volmute_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hook = 0, speech = 0, dialing = 0;
  logic       vol = 0, up = 0, dn = 0, mute = 0, other = 0;
  logic [2:0] gain;
  logic       mic_mute, rx_mute, remind;

  int total = 0;
  int bad = 0;

  int m_gain = 0;
  bit m_boost = 0, m_priv = 0, m_hook = 0;

  volmute_ctrl i_volmute_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hook_i(hook), .speech_i(speech),
    .dialing_i(dialing), .vol_key_i(vol), .up_key_i(up), .dn_key_i(dn),
    .mute_key_i(mute), .other_key_i(other), .gain_o(gain),
    .mic_mute_o(mic_mute), .rx_mute_o(rx_mute), .remind_o(remind)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int up_step(int g);
    return (g < 3) ? g + 1 : g;
  endfunction

  function automatic int dn_step(int g);
    return (g > -2) ? g - 1 : g;
  endfunction

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // reference update from the inputs present before the edge
  task automatic model_step();
    bit rise;
    rise = hook && !m_hook;
    m_hook = hook;
    if (rise) begin
      m_gain = 0; m_boost = 0; m_priv = 0;
    end else begin
      if (vol) begin
        m_gain = m_boost ? 0 : 2;
        m_boost = !m_boost;
      end else if (up) begin
        m_boost = 0; m_gain = up_step(m_gain);
      end else if (dn) begin
        m_boost = 0; m_gain = dn_step(m_gain);
      end
      if (vol || up || dn || other) m_priv = 0;
      else if (mute && speech) m_priv = !m_priv;
    end
  endtask

  task automatic cyc(string req);
    model_step();
    @(posedge clk);
    #1;
    check({req, " gain"}, $signed(gain), m_gain);
    check({req, " mic_mute"}, int'(mic_mute), int'(m_priv));
    check("R9 remind", int'(remind), int'(m_priv));
    check("R9 rx_mute", int'(rx_mute), int'(dialing));
    @(negedge clk);
    {vol, up, dn, mute, other} = '0;
  endtask

  task automatic press(input logic [4:0] k, string req);
    {vol, up, dn, mute, other} = k;
    cyc(req);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLK_PERIOD * 2 + 1);
    check("R1 gain", $signed(gain), 0);
    check("R1 mic_mute", int'(mic_mute), 0);
    check("R1 remind", int'(remind), 0);
    @(negedge clk);
    rst_n = 1'b1;
    hook = 1'b1;
    speech = 1'b1;
    cyc("R6 first hook");
    // R3 saturation high
    for (int i = 0; i < 5; i++) press(5'b01000, "R3");
    check("R3 held at max", $signed(gain), 3);
    // R4 saturation low
    for (int i = 0; i < 7; i++) press(5'b00100, "R4");
    check("R4 held at min", $signed(gain), -2);
    // R2 toggle, R5 step releases boost
    press(5'b10000, "R2 engage");
    check("R2 boost", $signed(gain), 2);
    press(5'b10000, "R2 release");
    check("R2 default", $signed(gain), 0);
    press(5'b10000, "R2 engage");
    press(5'b01000, "R5 up from boost");
    check("R5 up from boost", $signed(gain), 3);
    press(5'b10000, "R5 reboost");
    check("R5 boost re-engaged", $signed(gain), 2);
    press(5'b11100, "R5 priority");
    // R7 / R8
    press(5'b00010, "R7 mute on");
    check("R7 muted", int'(mic_mute), 1);
    speech = 1'b0;
    press(5'b00010, "R7 ignored");
    check("R7 ignored outside speech", int'(mic_mute), 1);
    speech = 1'b1;
    press(5'b00011, "R8 other beats mute");
    check("R8 cancelled", int'(mic_mute), 0);
    press(5'b00010, "R7 mute on");
    dialing = 1'b1;
    press(5'b01000, "R8 up cancels");
    dialing = 1'b0;
    // R6 hook rise with keys present
    press(5'b00010, "R7 mute on");
    hook = 1'b0;
    cyc("R6 on-hook");
    hook = 1'b1;
    press(5'b10000, "R6 rise beats key");
    check("R6 cleared", $signed(gain), 0);
    // random phase, R10 timing checked every cycle
    for (int n = 0; n < 3000; n++) begin
      vol     = ($urandom % 7) == 0;
      up      = ($urandom % 5) == 0;
      dn      = ($urandom % 5) == 0;
      mute    = ($urandom % 4) == 0;
      other   = ($urandom % 9) == 0;
      speech  = ($urandom % 4) != 0;
      dialing = ($urandom % 6) == 0;
      if (($urandom % 40) == 0) hook = ~hook;
      cyc("R10 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule